// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block drives the command pins of a synchronous DRAM from reset until the memory is ready for use. It then keeps the memory refreshed for as long as it runs. After reset it holds the bus at NOP for the power-up wait. It then closes every bank with a precharge-all and issues a train of auto-refresh commands. Next it writes the mode register with a key fixed at build time. It raises its ready flag only after the mode-write settle time has run out. Every wait is a parameter in nanoseconds. The block turns each wait into whole clock cycles from the clock period parameter.

Once ready, the block splits the memory between its own periodic refresh and a single requester. The requester raises a request and owns the bus for as long as the grant stays high. A refresh that falls due waits until the requester lets go. It then runs as precharge-all, a precharge wait, auto-refresh and a row-cycle wait. A refresh that is still pending takes priority over a fresh request. If a whole refresh interval passes while a refresh is still unserved, a late flag rises.

Top module: `sdram_init_refresh_seq`

## Requirements
- R1: While reset is low, the command pins show NOP ({cs_n,ras_n,cas_n,we_n} = 0111). The ready flag, the grant, the busy flag and the late flag are all low.
- R2: After reset is released, the pins stay at NOP for exactly ceil(PWRUP_NS/CLK_NS) cycles. The first command is then precharge-all (0010) with address bit A10_BIT high.
- R3: The first of INIT_REFRESHES auto-refresh commands (0001) follows the precharge by ceil(TRP_NS/CLK_NS) cycles. Consecutive refreshes are ceil(TRC_NS/CLK_NS) cycles apart.
- R4: The mode write (0000) follows the last start-up refresh by ceil(TRC_NS/CLK_NS) cycles and carries MODE_KEY on the address pins.
- R5: init_done rises exactly MRD_CYC cycles after the mode write and stays high until reset.
- R6: Each command lasts one cycle. The pins show NOP in every cycle in which no command is issued.
- R7: usr_grant is never high before init_done. When the block is idle and usr_req is high, the grant rises one cycle later. It stays high while usr_req stays high and falls in the cycle after usr_req drops.
- R8: After init_done rises, a refresh falls due every ceil(REFI_NS/CLK_NS) cycles. With the bus idle, the precharge of each periodic refresh appears one cycle after the refresh falls due.
- R9: A periodic refresh is precharge-all with A10_BIT high, then auto-refresh after the precharge wait. refresh_busy is high from the precharge cycle until the row-cycle wait after the refresh has run out.
- R10: A pending refresh wins over a request seen in the same cycle. The grant rises no earlier than the cycle after refresh_busy falls.
- R11: No refresh command is issued while usr_grant is high.
- R12: refresh_overdue rises when a refresh falls due while the previous one is still unserved. It clears in the cycle the refresh precharge is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| usr_req | input | 1 | Requester asks for (and keeps) ownership of the memory |
| usr_grant | output | 1 | Requester owns the memory |
| init_done | output | 1 | Start-up sequence complete |
| refresh_busy | output | 1 | A periodic refresh sequence is in progress |
| refresh_overdue | output | 1 | A refresh has been waiting for more than one interval |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address pins (A10_BIT selects all banks on precharge; mode key on mode write) |

## Verification
The bench builds the block with a 20 ns clock and a 400 ns power-up wait, which gives 20 cycles. It uses a 50 ns precharge wait (3 cycles), a 70 ns row cycle (4 cycles) and a 2000 ns refresh interval (100 cycles). The precharge wait and the row cycle therefore differ, so a swapped wait shows up as a wrong gap. The short power-up wait and interval put the whole start-up train within a few dozen cycles. They also bring two missed intervals, the late flag, the priority clash and two idle periodic refreshes inside a few hundred cycles. The mode key 0x032 differs from the default, so the bench can see that the key parameter reaches the pins.

// File: rtl/sdrinit_pkg.sv
`timescale 1ns/1ps
package sdrinit_pkg;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_MRS = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_NOP = 4'b0111
   } sdr_cmd_e;

   typedef enum logic [2:0] {
      ST_PWRUP,   // holding NOP for the power-up wait
      ST_IPRE,    // start-up precharge issued, waiting tRP
      ST_IREF,    // start-up refresh issued, waiting tRC
      ST_MRSW,    // mode written, waiting settle time
      ST_READY,   // idle, arbitrating
      ST_USER,    // requester owns the bus
      ST_RPRE,    // periodic precharge issued, waiting tRP
      ST_RREF     // periodic refresh issued, waiting tRC
   } seq_state_e;

   function automatic int cycles_for(input int ns, input int clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdrinit_wait_timer.sv
`timescale 1ns/1ps
module sdrinit_wait_timer #(
   parameter int CNT_W = 8,
   parameter int START = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   generate
      if (START >= (2 ** CNT_W)) begin : g_bad_start
         $error("sdrinit_wait_timer: START does not fit in CNT_W bits");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)               cnt_q <= CNT_W'(START);
      else if (load)            cnt_q <= load_val;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   AST_TIMER_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !expired) |=> ((cnt_q + 1'b1) == $past(cnt_q))); // R3

endmodule

// File: rtl/sdrinit_refresh_clock.sv
`timescale 1ns/1ps
module sdrinit_refresh_clock #(
   parameter int INTERVAL   = 1560,
   parameter bit TRACK_LATE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic ack,
   output logic pending,
   output logic overdue
);

   localparam int IW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

   generate
      if (INTERVAL < 2) begin : g_bad_interval
         $error("sdrinit_refresh_clock: INTERVAL must be at least 2 cycles");
      end
   endgenerate

   logic [IW-1:0] ivl_q;
   logic          tick;
   logic          pend_q;

   assign tick = run && (ivl_q == IW'(INTERVAL - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)    ivl_q <= '0;
      else if (run)  ivl_q <= tick ? '0 : ivl_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    pend_q <= 1'b0;
      else if (tick) pend_q <= 1'b1;
      else if (ack)  pend_q <= 1'b0;
   end

   assign pending = pend_q;

   generate
      if (TRACK_LATE) begin : g_late
         logic late_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                          late_q <= 1'b0;
            else if (tick && pend_q && !ack)     late_q <= 1'b1;
            else if (ack)                        late_q <= 1'b0;
         end
         assign overdue = late_q;
      end else begin : g_no_late
         assign overdue = 1'b0;
      end
   endgenerate

   AST_LATE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      overdue |-> pend_q); // R12

endmodule

// File: rtl/sdrinit_ctrl.sv
`timescale 1ns/1ps
module sdrinit_ctrl
   import sdrinit_pkg::*;
#(
   parameter int              ADDR_W         = 12,
   parameter int              A10_BIT        = 10,
   parameter logic [ADDR_W-1:0] MODE_KEY     = '0,
   parameter int              INIT_REFRESHES = 8,
   parameter int              TRP_CYC        = 2,
   parameter int              TRC_CYC        = 7,
   parameter int              MRD_CYC        = 3,
   parameter int              CNT_W          = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              usr_req,
   input  logic              ref_pending,
   input  logic              wait_done,
   output logic [3:0]        cmd_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              tmr_load,
   output logic [CNT_W-1:0]  tmr_val,
   output logic              ref_ack,
   output logic              init_done,
   output logic              usr_grant,
   output logic              refresh_busy
);

   localparam int RN_W = $clog2(INIT_REFRESHES + 1);

   seq_state_e        state_q, state_d;
   sdr_cmd_e          cmd_q, cmd_d;
   logic [ADDR_W-1:0] addr_q, addr_d;
   logic [RN_W-1:0]   rnum_q, rnum_d;
   logic              done_q, done_d;
   logic              grant_q, grant_d;
   logic              busy_q, busy_d;

   always_comb begin
      state_d  = state_q;
      cmd_d    = CMD_NOP;
      addr_d   = '0;
      rnum_d   = rnum_q;
      done_d   = done_q;
      grant_d  = grant_q;
      busy_d   = busy_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      ref_ack  = 1'b0;
      case (state_q)
         ST_PWRUP: if (wait_done) begin
            cmd_d           = CMD_PRE;
            addr_d[A10_BIT] = 1'b1;
            tmr_load        = 1'b1;
            tmr_val         = CNT_W'(TRP_CYC - 1);
            state_d         = ST_IPRE;
         end
         ST_IPRE: if (wait_done) begin
            cmd_d    = CMD_REF;
            rnum_d   = RN_W'(1);
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(TRC_CYC - 1);
            state_d  = ST_IREF;
         end
         ST_IREF: if (wait_done) begin
            if (rnum_q == RN_W'(INIT_REFRESHES)) begin
               cmd_d    = CMD_MRS;
               addr_d   = MODE_KEY;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(MRD_CYC - 1);
               state_d  = ST_MRSW;
            end else begin
               cmd_d    = CMD_REF;
               rnum_d   = rnum_q + 1'b1;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(TRC_CYC - 1);
            end
         end
         ST_MRSW: if (wait_done) begin
            done_d  = 1'b1;
            state_d = ST_READY;
         end
         ST_READY: begin
            if (ref_pending) begin
               cmd_d           = CMD_PRE;
               addr_d[A10_BIT] = 1'b1;
               ref_ack         = 1'b1;
               busy_d          = 1'b1;
               tmr_load        = 1'b1;
               tmr_val         = CNT_W'(TRP_CYC - 1);
               state_d         = ST_RPRE;
            end else if (usr_req) begin
               grant_d = 1'b1;
               state_d = ST_USER;
            end
         end
         ST_USER: if (!usr_req) begin
            grant_d = 1'b0;
            state_d = ST_READY;
         end
         ST_RPRE: if (wait_done) begin
            cmd_d    = CMD_REF;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(TRC_CYC - 1);
            state_d  = ST_RREF;
         end
         ST_RREF: if (wait_done) begin
            busy_d  = 1'b0;
            state_d = ST_READY;
         end
         default: state_d = ST_PWRUP;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_PWRUP;
         cmd_q   <= CMD_NOP;
         addr_q  <= '0;
         rnum_q  <= '0;
         done_q  <= 1'b0;
         grant_q <= 1'b0;
         busy_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         cmd_q   <= cmd_d;
         addr_q  <= addr_d;
         rnum_q  <= rnum_d;
         done_q  <= done_d;
         grant_q <= grant_d;
         busy_q  <= busy_d;
      end
   end

   assign cmd_o        = cmd_q;
   assign addr_o       = addr_q;
   assign init_done    = done_q;
   assign usr_grant    = grant_q;
   assign refresh_busy = busy_q;

   AST_GRANT_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      grant_q |-> done_q); // R7
   AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q != CMD_NOP) |=> (cmd_q == CMD_NOP)); // R6
   AST_NO_REF_WHILE_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_REF) |-> !grant_q); // R11
   AST_BUSY_BLOCKS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !grant_q); // R10
   AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_PRE) |-> addr_q[A10_BIT]); // R2
   AST_MODE_KEY_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_MRS) |-> (addr_q == MODE_KEY)); // R4
   AST_READY_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> done_q); // R5

endmodule

// File: rtl/sdram_init_refresh_seq.sv
`timescale 1ns/1ps
module sdram_init_refresh_seq
   import sdrinit_pkg::*;
#(
   parameter int                CLK_NS         = 10,
   parameter int                PWRUP_NS       = 200000,
   parameter int                TRP_NS         = 20,
   parameter int                TRC_NS         = 70,
   parameter int                REFI_NS        = 15600,
   parameter int                MRD_CYC        = 3,
   parameter int                INIT_REFRESHES = 8,
   parameter int                ADDR_W         = 12,
   parameter int                A10_BIT        = 10,
   parameter logic [ADDR_W-1:0] MODE_KEY       = ADDR_W'(12'h022),
   parameter bit                TRACK_LATE     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              usr_req,
   output logic              usr_grant,
   output logic              init_done,
   output logic              refresh_busy,
   output logic              refresh_overdue,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [ADDR_W-1:0] sd_addr
);

   localparam int PWRUP_CYC = max_of(1, cycles_for(PWRUP_NS, CLK_NS));
   localparam int TRP_CYC   = max_of(1, cycles_for(TRP_NS, CLK_NS));
   localparam int TRC_CYC   = max_of(1, cycles_for(TRC_NS, CLK_NS));
   localparam int REFI_CYC  = cycles_for(REFI_NS, CLK_NS);
   localparam int WAIT_MAX  = max_of(max_of(PWRUP_CYC, TRP_CYC), max_of(TRC_CYC, MRD_CYC));
   localparam int CNT_W     = $clog2(WAIT_MAX + 1);

   generate
      if (CLK_NS < 1) begin : g_bad_clk
         $error("sdram_init_refresh_seq: CLK_NS must be positive");
      end
      if (INIT_REFRESHES < 8) begin : g_bad_nref
         $error("sdram_init_refresh_seq: at least eight start-up refreshes are required");
      end
      if (A10_BIT >= ADDR_W) begin : g_bad_a10
         $error("sdram_init_refresh_seq: A10_BIT outside the address bus");
      end
      if (MRD_CYC < 1) begin : g_bad_mrd
         $error("sdram_init_refresh_seq: MRD_CYC must be at least 1");
      end
      if (REFI_CYC <= TRP_CYC + TRC_CYC + 1) begin : g_bad_refi
         $error("sdram_init_refresh_seq: refresh interval shorter than one refresh sequence");
      end
   endgenerate

   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_expired;
   logic             ref_pending;
   logic             ref_ack;
   logic [3:0]       cmd_w;

   sdrinit_wait_timer #(
      .CNT_W (CNT_W),
      .START (PWRUP_CYC)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   sdrinit_refresh_clock #(
      .INTERVAL   (REFI_CYC),
      .TRACK_LATE (TRACK_LATE)
   ) u_refclk (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (init_done),
      .ack     (ref_ack),
      .pending (ref_pending),
      .overdue (refresh_overdue)
   );

   sdrinit_ctrl #(
      .ADDR_W         (ADDR_W),
      .A10_BIT        (A10_BIT),
      .MODE_KEY       (MODE_KEY),
      .INIT_REFRESHES (INIT_REFRESHES),
      .TRP_CYC        (TRP_CYC),
      .TRC_CYC        (TRC_CYC),
      .MRD_CYC        (MRD_CYC),
      .CNT_W          (CNT_W)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .usr_req      (usr_req),
      .ref_pending  (ref_pending),
      .wait_done    (tmr_expired),
      .cmd_o        (cmd_w),
      .addr_o       (sd_addr),
      .tmr_load     (tmr_load),
      .tmr_val      (tmr_val),
      .ref_ack      (ref_ack),
      .init_done    (init_done),
      .usr_grant    (usr_grant),
      .refresh_busy (refresh_busy)
   );

   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_w;

endmodule

// File: tb/sdram_init_refresh_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_init_refresh_seq_tb_top;

   localparam int          CLK_NS  = 20;
   localparam int          PWR_NS  = 400;
   localparam int          TRP_NS  = 50;
   localparam int          TRC_NS  = 70;
   localparam int          REFI_NS = 2000;
   localparam int          MRD_C   = 3;
   localparam logic [11:0] KEY     = 12'h032;

   localparam int PWR_C  = (PWR_NS + CLK_NS - 1) / CLK_NS;
   localparam int TRP_C  = (TRP_NS + CLK_NS - 1) / CLK_NS;
   localparam int TRC_C  = (TRC_NS + CLK_NS - 1) / CLK_NS;
   localparam int REFI_C = (REFI_NS + CLK_NS - 1) / CLK_NS;

   localparam logic [3:0] C_NOP = 4'b0111;
   localparam logic [3:0] C_PRE = 4'b0010;
   localparam logic [3:0] C_REF = 4'b0001;
   localparam logic [3:0] C_MRS = 4'b0000;

   // start-up train: expected command and gap to the next event
   localparam logic [3:0] EXP_CMD [10] = '{C_PRE, C_REF, C_REF, C_REF, C_REF,
                                           C_REF, C_REF, C_REF, C_REF, C_MRS};
   localparam int         EXP_GAP [10] = '{TRP_C, TRC_C, TRC_C, TRC_C, TRC_C,
                                           TRC_C, TRC_C, TRC_C, TRC_C, MRD_C};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        usr_req = 1'b0;
   logic        usr_grant, init_done, refresh_busy, refresh_overdue;
   logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [11:0] sd_addr;

   always #10 clk = ~clk;

   sdram_init_refresh_seq #(
      .CLK_NS (CLK_NS), .PWRUP_NS (PWR_NS), .TRP_NS (TRP_NS), .TRC_NS (TRC_NS),
      .REFI_NS (REFI_NS), .MRD_CYC (MRD_C), .INIT_REFRESHES (8), .ADDR_W (12),
      .A10_BIT (10), .MODE_KEY (KEY), .TRACK_LATE (1'b1)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .usr_req (usr_req), .usr_grant (usr_grant),
      .init_done (init_done), .refresh_busy (refresh_busy),
      .refresh_overdue (refresh_overdue), .sd_cs_n (sd_cs_n), .sd_ras_n (sd_ras_n),
      .sd_cas_n (sd_cas_n), .sd_we_n (sd_we_n), .sd_addr (sd_addr)
   );

   wire [3:0] cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 1'b0;
   bit early_grant = 1'b0;

   logic [3:0]  lg_cmd  [64];
   logic [11:0] lg_addr [64];
   int          lg_cyc  [64];
   int          lg_n = 0;

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   always @(negedge clk) begin
      if (rst_n && cmd != C_NOP && lg_n < 64) begin
         lg_cmd[lg_n]  = cmd;
         lg_addr[lg_n] = sd_addr;
         lg_cyc[lg_n]  = cyc;
         lg_n          = lg_n + 1;
      end
      if (rst_n && usr_grant && !init_done) early_grant = 1'b1;
   end

   task automatic chk(input string rq, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   task automatic go_to(input int k);
      while (cyc < k) @(negedge clk);
   endtask

   function automatic int find_cmd(input logic [3:0] c, input int from);
      for (int i = 0; i < lg_n; i++)
         if (lg_cmd[i] == c && lg_cyc[i] >= from) return lg_cyc[i];
      return -1;
   endfunction

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL R5 watchdog: actual %0d cycles expected completion earlier", 5000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int d;
      int x;
      int nxt;
      usr_req = 1'b1;   // requester asks from the start (R7: must wait for init)
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "command during reset", int'(cmd), int'(C_NOP));
      chk("R1", "init_done during reset", int'(init_done), 0);
      chk("R1", "grant during reset", int'(usr_grant), 0);
      chk("R1", "busy during reset", int'(refresh_busy), 0);
      chk("R1", "overdue during reset", int'(refresh_overdue), 0);
      rst_n = 1'b1;

      while (!init_done && cyc < 1000) @(negedge clk);
      d = cyc;

      // start-up train walked from the table (R2, R3, R4, R5)
      chk("R2", "first command cycle (NOP run length + 1)", lg_n > 0 ? lg_cyc[0] : -1, PWR_C + 1);
      chk("R2", "precharge A10", lg_n > 0 ? int'(lg_addr[0][10]) : -1, 1);
      chk("R6", "commands logged before init_done", lg_n, 10);
      for (int i = 0; i < 10; i++) begin
         nxt = (i < 9) ? lg_cyc[i+1] : d;
         chk((i == 0) ? "R2" : ((i == 9) ? "R4" : "R3"), $sformatf("init command %0d code", i),
             int'(lg_cmd[i]), int'(EXP_CMD[i]));
         chk((i < 8) ? "R3" : ((i == 8) ? "R4" : "R5"), $sformatf("init gap after command %0d", i),
             nxt - lg_cyc[i], EXP_GAP[i]);
      end
      chk("R4", "mode key on address", int'(lg_addr[9]), int'(KEY));
      chk("R7", "grant seen before init_done", int'(early_grant), 0);

      go_to(d + 1);
      chk("R7", "grant one cycle after ready", int'(usr_grant), 1);
      chk("R5", "init_done stays high", int'(init_done), 1);

      // hold the bus across two intervals: refresh must wait (R11), late flag (R12)
      go_to(d + 2 * REFI_C - 1);
      chk("R12", "overdue before second interval", int'(refresh_overdue), 0);
      go_to(d + 2 * REFI_C);
      chk("R12", "overdue after missed interval", int'(refresh_overdue), 1);
      chk("R11", "no command while granted", lg_n, 10);
      chk("R7", "grant held while request high", int'(usr_grant), 1);

      // release for one cycle, then request again: refresh wins (R10)
      x = d + 2 * REFI_C + 10;
      go_to(x);
      usr_req = 1'b0;
      go_to(x + 1);
      chk("R7", "grant falls after release", int'(usr_grant), 0);
      usr_req = 1'b1;
      for (int k = x + 2; k <= x + 2 + TRP_C + TRC_C + 1; k++) begin
         go_to(k);
         chk("R9", $sformatf("busy at cycle %0d", k), int'(refresh_busy),
             (k <= x + 1 + TRP_C + TRC_C) ? 1 : 0);
         chk("R10", $sformatf("grant at cycle %0d", k), int'(usr_grant),
             (k == x + 2 + TRP_C + TRC_C + 1) ? 1 : 0);
         if (k == x + 2) chk("R12", "overdue clears at precharge", int'(refresh_overdue), 0);
      end
      chk("R10", "precharge beats new request", find_cmd(C_PRE, x + 1), x + 2);
      chk("R9", "periodic precharge A10", int'(lg_addr[10][10]), 1);
      chk("R9", "refresh after precharge wait", find_cmd(C_REF, x + 1), x + 2 + TRP_C);

      // release and let periodic refresh run on an idle bus (R8)
      go_to(x + 15);
      usr_req = 1'b0;
      go_to(d + 4 * REFI_C + 5);
      chk("R8", "periodic precharge at interval", find_cmd(C_PRE, x + 16), d + 3 * REFI_C + 1);
      chk("R8", "next periodic precharge", find_cmd(C_PRE, d + 3 * REFI_C + 2), d + 4 * REFI_C + 1);
      chk("R9", "periodic refresh follows", find_cmd(C_REF, d + 4 * REFI_C + 1), d + 4 * REFI_C + 1 + TRP_C);
      chk("R12", "no overdue on idle bus", int'(refresh_overdue), 0);
      chk("R7", "grant low after release", int'(usr_grant), 0);
      for (int i = 0; i + 1 < lg_n; i++)
         chk("R6", $sformatf("commands %0d/%0d not adjacent", i, i + 1),
             int'(lg_cyc[i+1] - lg_cyc[i] > 1), 1);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule